// File: doc/BRIEF.md
# Prescaled Line-State Noise Timer

This block times how long a serial link receiver spends in noisy or active line states without passing through a clean state. Two down-counters are chained. A prescale stage counts base ticks and wraps from its programmed threshold. The noise stage steps down once each time the prescale stage wraps. When both stages are at zero the block raises a sticky noise status flag.

Clean line states hold both stages at their thresholds. Noise and active states let the count run, and re-arm the count when it expires. The unknown state lets the count run, but the count then stays at zero. Host writes to either threshold register restart the count with the value just written.

The base tick is a single-cycle enable pulse, nominally every 80 ns, on an otherwise free-running clock. With noise threshold N and prescale threshold P, expiry comes N·(P+1)+P ticks after the last reload. The reset values N = 0x40 and P = 0xF9 give roughly 1.3 ms.

Top module: `lsn_noise_timer`

## Requirements
- R1: After reset the noise threshold reads 0x40, the prescale threshold reads 0xF9 and the noise flag is 0.
- R2: The noise threshold register is at address 0x0D and holds 7 bits in data bits 6..0. Data bit 7 reads 0, and a write to it has no effect.
- R3: The prescale threshold register is at address 0x0E and holds 8 bits. A read of any other address returns 0.
- R4: Line-state codes are 0 quiet, 1 idle, 2 halt, 3 master, 4 active, 5 noise, 6 unknown and 7 no-signal. In codes 4, 5 and 6, with no reload, the noise flag rises one clock after the tick that brings both stages to zero, which is tick number N·(P+1)+P after the last reload.
- R5: While the line state is clean (codes 0, 1, 2, 3 or 7), both stages load their thresholds every clock, and the flag is never set.
- R6: A write to either threshold register reloads both stages, using the value just written.
- R7: A change among codes 4, 5 and 6 does not reload either stage, so the count carries on across the change.
- R8: In codes 4 and 5, once both stages reach zero they reload together, and a full new period starts.
- R9: In code 6, once both stages reach zero they stay at zero, so the flag is set again on every clock.
- R10: The flag stays set until a clear strobe. If a set and a clear fall in the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle base tick enable |
| lstate_i | input | 3 | Decoded line-state code |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| flag_clr_i | input | 1 | Clear strobe for the noise flag |
| noise_flag_o | output | 1 | Sticky noise-threshold flag |

## Verification
Read data is combinational, so the bench samples it one time step after it drives the address. A tick held over one rising edge updates the counters at that edge. The flag follows at the next edge, one clock later. Each flag check therefore comes one full clock after the last tick pulse. That check is made once after the period less one tick, where 0 is expected, and once after the final tick, where 1 is expected. This pins the expiry to an exact tick count. Clear strobes, set-wins cases and line-state changes are driven at falling edges and checked at the falling edge that follows the edge they act on.

// File: rtl/lsn_pkg.sv
`timescale 1ns/1ps
package lsn_pkg;

  typedef enum logic [2:0] {
    LS_QUIET   = 3'd0,
    LS_IDLE    = 3'd1,
    LS_HALT    = 3'd2,
    LS_MASTER  = 3'd3,
    LS_ACTIVE  = 3'd4,
    LS_NOISE   = 3'd5,
    LS_UNKNOWN = 3'd6,
    LS_NOSIG   = 3'd7
  } line_state_e;

  // clean states hold the timer at its thresholds
  function automatic logic ls_is_clean(input line_state_e s);
    return (s == LS_QUIET) || (s == LS_IDLE) || (s == LS_HALT) ||
           (s == LS_MASTER) || (s == LS_NOSIG);
  endfunction

  // states in which an expired count re-arms itself
  function automatic logic ls_rearms(input line_state_e s);
    return (s == LS_NOISE) || (s == LS_ACTIVE);
  endfunction

endpackage

// File: rtl/lsn_thr_regs.sv
`timescale 1ns/1ps
module lsn_thr_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NT_W   = 7,
  parameter int PS_W   = 8,
  parameter logic [ADDR_W-1:0] NT_ADDR = 8'h0D,
  parameter logic [ADDR_W-1:0] PS_ADDR = 8'h0E,
  parameter logic [NT_W-1:0]   NT_RST  = 7'h40,
  parameter logic [PS_W-1:0]   PS_RST  = 8'hF9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NT_W-1:0]   nt_thr_o,
  output logic [PS_W-1:0]   ps_thr_o,
  output logic [NT_W-1:0]   nt_thr_nxt_o,
  output logic [PS_W-1:0]   ps_thr_nxt_o,
  output logic              thr_wr_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              nt_hit, ps_hit;
  logic [NT_W-1:0]   nt_q, nt_d;
  logic [PS_W-1:0]   ps_q, ps_d;
  logic [DATA_W-1:0] nt_rd, ps_rd;

  assign nt_hit = wr_i && (addr_i == NT_ADDR);
  assign ps_hit = wr_i && (addr_i == PS_ADDR);

  always_comb begin
    nt_d = nt_q;
    ps_d = ps_q;
    if (nt_hit) nt_d = wdata_i[NT_W-1:0];
    if (ps_hit) ps_d = wdata_i[PS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nt_q <= NT_RST;
      ps_q <= PS_RST;
    end else begin
      nt_q <= nt_d;
      ps_q <= ps_d;
    end
  end

  // zero-extend each threshold to the data width
  if (NT_W < DATA_W) begin : g_nt_pad
    assign nt_rd = {{(DATA_W-NT_W){1'b0}}, nt_q};
  end else begin : g_nt_full
    assign nt_rd = nt_q;
  end
  if (PS_W < DATA_W) begin : g_ps_pad
    assign ps_rd = {{(DATA_W-PS_W){1'b0}}, ps_q};
  end else begin : g_ps_full
    assign ps_rd = ps_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == NT_ADDR) rdata_o = nt_rd;
    else if (addr_i == PS_ADDR) rdata_o = ps_rd;
  end

  assign nt_thr_o     = nt_q;
  assign ps_thr_o     = ps_q;
  assign nt_thr_nxt_o = nt_d;
  assign ps_thr_nxt_o = ps_d;
  assign thr_wr_o     = nt_hit || ps_hit;

endmodule

// File: rtl/lsn_down_stage.sv
`timescale 1ns/1ps
module lsn_down_stage #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lsn_noise_ctrl.sv
`timescale 1ns/1ps
module lsn_noise_ctrl
  import lsn_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  line_state_e lstate_i,
  input  logic        tick_i,
  input  logic        thr_wr_i,
  input  logic        ps_zero_i,
  input  logic        nc_zero_i,
  input  logic        clr_i,
  output logic        ps_load_o,
  output logic        ps_dec_o,
  output logic        nc_load_o,
  output logic        nc_dec_o,
  output logic        flag_o
);

  logic clean, rearm, counting, both_zero, reload_all, step, set_evt;
  logic flag_q, flag_d;

  assign clean      = ls_is_clean(lstate_i);
  assign rearm      = ls_rearms(lstate_i);
  assign counting   = !clean;
  assign both_zero  = ps_zero_i && nc_zero_i;
  assign reload_all = clean || thr_wr_i || (both_zero && rearm);
  assign step       = tick_i && counting && !both_zero;

  assign ps_load_o = reload_all || (step && ps_zero_i);
  assign ps_dec_o  = step && !ps_zero_i;
  assign nc_load_o = reload_all;
  assign nc_dec_o  = step && ps_zero_i;

  assign set_evt = both_zero && counting;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)   flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/lsn_noise_timer.sv
`timescale 1ns/1ps
module lsn_noise_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NT_W   = 7,
  parameter int PS_W   = 8,
  parameter logic [ADDR_W-1:0] NT_ADDR = 8'h0D,
  parameter logic [ADDR_W-1:0] PS_ADDR = 8'h0E,
  parameter logic [NT_W-1:0]   NT_RST  = 7'h40,
  parameter logic [PS_W-1:0]   PS_RST  = 8'hF9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [2:0]        lstate_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              flag_clr_i,
  output logic              noise_flag_o
);

  logic [NT_W-1:0] nt_thr, nt_thr_nxt, nc_cnt;
  logic [PS_W-1:0] ps_thr, ps_thr_nxt, ps_cnt;
  logic thr_wr, ps_zero, nc_zero;
  logic ps_load, ps_dec, nc_load, nc_dec;

  lsn_thr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NT_W(NT_W), .PS_W(PS_W),
    .NT_ADDR(NT_ADDR), .PS_ADDR(PS_ADDR), .NT_RST(NT_RST), .PS_RST(PS_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .nt_thr_o(nt_thr), .ps_thr_o(ps_thr),
    .nt_thr_nxt_o(nt_thr_nxt), .ps_thr_nxt_o(ps_thr_nxt),
    .thr_wr_o(thr_wr), .rdata_o(reg_rdata_o)
  );

  lsn_down_stage #(.W(PS_W), .RST_VAL(PS_RST)) u_ps_stage (
    .clk(clk), .rst_n(rst_n), .load_i(ps_load), .load_val_i(ps_thr_nxt),
    .dec_i(ps_dec), .cnt_o(ps_cnt), .zero_o(ps_zero)
  );

  lsn_down_stage #(.W(NT_W), .RST_VAL(NT_RST)) u_nc_stage (
    .clk(clk), .rst_n(rst_n), .load_i(nc_load), .load_val_i(nt_thr_nxt),
    .dec_i(nc_dec), .cnt_o(nc_cnt), .zero_o(nc_zero)
  );

  lsn_noise_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .lstate_i(lsn_pkg::line_state_e'(lstate_i)),
    .tick_i(tick_i), .thr_wr_i(thr_wr), .ps_zero_i(ps_zero),
    .nc_zero_i(nc_zero), .clr_i(flag_clr_i), .ps_load_o(ps_load),
    .ps_dec_o(ps_dec), .nc_load_o(nc_load), .nc_dec_o(nc_dec),
    .flag_o(noise_flag_o)
  );

endmodule

// File: rtl/lsn_noise_timer_chk.sv
`timescale 1ns/1ps
module lsn_noise_timer_chk
  import lsn_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NT_W   = 7,
  parameter int PS_W   = 8,
  parameter logic [ADDR_W-1:0] NT_ADDR = 8'h0D,
  parameter logic [ADDR_W-1:0] PS_ADDR = 8'h0E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic [2:0]        lstate_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              flag_clr_i,
  input logic              noise_flag_o,
  input logic [PS_W-1:0]   ps_cnt,
  input logic [NT_W-1:0]   nc_cnt,
  input logic [PS_W-1:0]   ps_thr,
  input logic [NT_W-1:0]   nt_thr
);

  logic clean_s, rearm_s, unk_s, zero_s, wr_any;
  assign clean_s = ls_is_clean(line_state_e'(lstate_i));
  assign rearm_s = ls_rearms(line_state_e'(lstate_i));
  assign unk_s   = (line_state_e'(lstate_i) == LS_UNKNOWN);
  assign zero_s  = (ps_cnt == '0) && (nc_cnt == '0);
  assign wr_any  = reg_wr_i && ((reg_addr_i == NT_ADDR) || (reg_addr_i == PS_ADDR));

  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == NT_ADDR) |-> (reg_rdata_o[DATA_W-1:NT_W] == '0));

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_s && !clean_s) |=> noise_flag_o);

  a_r5_clean_load: assert property (@(posedge clk) disable iff (!rst_n)
    clean_s |=> (ps_cnt == ps_thr) && (nc_cnt == nt_thr));

  a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clean_s && !tick_i && !wr_any && !(zero_s && rearm_s))
      |=> $stable(ps_cnt) && $stable(nc_cnt));

  a_r9_unknown_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (unk_s && zero_s && !wr_any) |=> zero_s);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_flag_o && !flag_clr_i) |=> noise_flag_o);

  a_r10_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(noise_flag_o) |-> $past(flag_clr_i));

endmodule

bind lsn_noise_timer lsn_noise_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NT_W(NT_W), .PS_W(PS_W),
  .NT_ADDR(NT_ADDR), .PS_ADDR(PS_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .lstate_i(lstate_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .flag_clr_i(flag_clr_i), .noise_flag_o(noise_flag_o),
  .ps_cnt(ps_cnt), .nc_cnt(nc_cnt), .ps_thr(ps_thr), .nt_thr(nt_thr)
);

// File: tb/lsn_noise_timer_bench.sv
`timescale 1ns/1ps
module lsn_noise_timer_bench;
  import lsn_pkg::*;

  localparam logic [7:0] A_NT = 8'h0D;
  localparam logic [7:0] A_PS = 8'h0E;

  // fields: line state, noise threshold, prescale threshold, ticks to expiry
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd5, 8'd3, 8'd2, 8'd11},
    {8'd4, 8'd1, 8'd0, 8'd1},
    {8'd6, 8'd0, 8'd3, 8'd3},
    {8'd5, 8'd2, 8'd5, 8'd17},
    {8'd4, 8'd4, 8'd1, 8'd9},
    {8'd6, 8'd5, 8'd4, 8'd29}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] lstate = 3'd1;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       clr = 1'b0;
  logic       flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lsn_noise_timer u_lsn_noise_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .lstate_i(lstate),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .flag_clr_i(clr), .noise_flag_o(flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic set_ls(input logic [2:0] s);
    @(negedge clk); lstate = s;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(A_NT, rd); chk("R1 nt reset", rd, 8'h40);
    rd_reg(A_PS, rd); chk("R1 ps reset", rd, 8'hF9);
    chk("R1 flag reset", {7'd0, flag}, 8'h00);
    // R2 reserved bit
    wr_reg(A_NT, 8'hFF);
    rd_reg(A_NT, rd); chk("R2 bit7 ignored", rd, 8'h7F);
    // R3 prescale register and unmapped read
    wr_reg(A_PS, 8'hA5);
    rd_reg(A_PS, rd); chk("R3 ps rw", rd, 8'hA5);
    rd_reg(8'h00, rd); chk("R3 unmapped", rd, 8'h00);

    // R4 table of expiry periods
    for (int v = 0; v < NVEC; v++) begin
      set_ls(LS_IDLE);
      wr_reg(A_NT, VEC[v][23:16]);
      wr_reg(A_PS, VEC[v][15:8]);
      clear_flag();
      set_ls(VEC[v][26:24]);
      pulse(int'(VEC[v][7:0]) - 1);
      settle(); chk("R4 before expiry", {7'd0, flag}, 8'h00);
      pulse(1);
      settle(); chk("R4 at expiry", {7'd0, flag}, 8'h01);
    end

    // R5 clean state reloads
    set_ls(LS_IDLE);
    wr_reg(A_NT, 8'd3); wr_reg(A_PS, 8'd2);
    clear_flag();
    set_ls(LS_NOISE); pulse(8);
    set_ls(LS_HALT);
    settle(); chk("R5 no set while clean", {7'd0, flag}, 8'h00);
    set_ls(LS_NOISE); pulse(8);
    settle(); chk("R5 reload delays expiry", {7'd0, flag}, 8'h00);
    pulse(3);
    settle(); chk("R5 expiry after reload", {7'd0, flag}, 8'h01);

    // R6 write reload with new values (period 1*2+1 = 3)
    set_ls(LS_IDLE); clear_flag();
    set_ls(LS_ACTIVE); pulse(8);
    wr_reg(A_NT, 8'd1); wr_reg(A_PS, 8'd1);
    pulse(2);
    settle(); chk("R6 before expiry", {7'd0, flag}, 8'h00);
    pulse(1);
    settle(); chk("R6 at expiry", {7'd0, flag}, 8'h01);

    // R7 count carries across counting states (period 11)
    set_ls(LS_IDLE);
    wr_reg(A_NT, 8'd3); wr_reg(A_PS, 8'd2);
    clear_flag();
    set_ls(LS_NOISE); pulse(5);
    set_ls(LS_ACTIVE); pulse(3);
    set_ls(LS_UNKNOWN); pulse(2);
    settle(); chk("R7 before expiry", {7'd0, flag}, 8'h00);
    pulse(1);
    settle(); chk("R7 at expiry", {7'd0, flag}, 8'h01);

    // R10 set wins over clear, then R8 re-arm in noise
    set_ls(LS_IDLE); clear_flag();
    set_ls(LS_NOISE); pulse(10);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R10 set wins", {7'd0, flag}, 8'h01);
    clear_flag();
    chk("R10 clear", {7'd0, flag}, 8'h00);
    pulse(10);
    settle(); chk("R8 rearmed before expiry", {7'd0, flag}, 8'h00);
    pulse(1);
    settle(); chk("R8 rearmed expiry", {7'd0, flag}, 8'h01);

    // R9 unknown holds at zero
    set_ls(LS_IDLE); clear_flag();
    set_ls(LS_UNKNOWN); pulse(11);
    settle(); chk("R9 expiry", {7'd0, flag}, 8'h01);
    clear_flag();
    chk("R9 flag re-set while held", {7'd0, flag}, 8'h01);
    set_ls(LS_IDLE); clear_flag();
    chk("R10 clear in clean state", {7'd0, flag}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule